// File: doc/BRIEF.md
# Filtered Quadrature Encoder Counter

This block follows two rotary or linear encoders at once. Every encoder supplies an in-phase line and a quadrature line. Each line first passes through a two-flop synchroniser. It then goes through a glitch filter, which adopts a new level only after that level has been seen on three consecutive sample ticks. A shared programmable prescaler sets the tick rate. The filtered pair drives a four-times decoder: every legal edge moves that channel's counter one step up or down. A jump of both lines in the same cycle is discarded.

Each counter runs either 8 or 10 bits wide. Wrapping past the top sets a sticky overflow flag, and wrapping below zero sets a sticky underflow flag. An enable bit for each flag lets it drive a single interrupt line. Software uses a flat word-wide register port with a write strobe and a combinational read port. Through it, software loads or clears each count, selects the counter width, sets the interrupt enables, clears the flags and programs the prescaler.

Top module: `quad_encoder_counter`

## Requirements
- R1: After reset, both counts, the control word, the flag word and the prescaler read 0, and `irq` is low.
- R2: The phase sequence {I,Q} = 00→10→11→01→00 advances the count by one per edge.
- R3: The reverse sequence 00→01→11→10→00 lowers the count by one per edge.
- R4: When both filtered lines change in the same cycle, the count does not change.
- R5: A level that lasts fewer than three sample ticks never reaches the decoder and leaves the count unchanged.
- R6: Narrow mode, selected by control bit 4c=0 for channel c, wraps 255→0 and sets overflow flag bit 2c, and wraps 0→255 and sets underflow flag bit 2c+1.
- R7: Wide mode, selected by control bit 4c=1, counts through 256 and wraps 1023→0, setting the overflow flag.
- R8: A write to address c loads count c. The load wins over a decoder step in the same cycle, and that step is lost.
- R9: Flags at address 3 (2 for 2 channels + 1) stay set until software writes 1 to them. Writing 0 leaves them as they are.
- R10: `irq` is high only while some flag is set and its enable is set: control bit 4c+1 enables overflow of channel c and control bit 4c+2 enables its underflow.
- R11: The channels are independent: stepping one never changes the other's count.
- R12: The prescaler at address 4 makes a sample tick every (value+1) clocks, so a 7-clock pulse is rejected at value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_i | input | 2 | In-phase encoder line, one per channel |
| enc_q | input | 2 | Quadrature encoder line, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0,1 counts, 2 control, 3 flags, 4 prescaler |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The decoder is driven with clean forward and reverse Gray sequences, which separate the two counting directions. It also gets a simultaneous flip of both lines, which must be told apart from a legal single-line edge. Short pulses of two clocks at the fastest tick and seven clocks at a slow tick separate noise from real edges and show that the filter window scales with the prescaler. A load issued in exactly the cycle a step lands exposes the priority order. Runs started near 255, 1023 and 0 distinguish the narrow wrap from the wide wrap and overflow from underflow.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } qdec_step_t;

  // Position of an {I,Q} pair along the forward Gray cycle 00,10,11,01
  function automatic logic [1:0] qdec_phase(input logic i, input logic q);
    case ({i, q})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qdec_input_filter.sv
module qdec_input_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  logic [1:0]       sync_q;
  logic [DEPTH-2:0] hist_q, hist_d;
  logic             filt_q, filt_d;
  logic [DEPTH-1:0] window;

  assign window = {hist_q, sync_q[1]};

  always_comb begin
    hist_d = hist_q;
    filt_d = filt_q;
    if (tick) begin
      hist_d = window[DEPTH-2:0];
      if (&window)       filt_d = 1'b1;
      else if (~|window) filt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i_f,
  input  logic       q_f,
  output qdec_step_t step
);
  logic [1:0] prev_q;
  logic [1:0] diff;

  always_comb begin
    diff    = qdec_phase(i_f, q_f) - qdec_phase(prev_q[1], prev_q[0]);
    step.up = (diff == 2'd1);
    step.dn = (diff == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= {i_f, q_f};
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  qdec_step_t        step,
  input  logic              load,
  input  logic [WIDE_W-1:0] load_val,
  output logic [WIDE_W-1:0] cnt,
  output logic              ovf,
  output logic              unf
);
  localparam logic [WIDE_W-1:0] NARROW_MAX =
    {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] cnt_q, cnt_d, mask, cur;

  always_comb begin
    mask  = wide ? {WIDE_W{1'b1}} : NARROW_MAX;
    cur   = cnt_q & mask;
    cnt_d = cur;
    ovf   = 1'b0;
    unf   = 1'b0;
    if (load) begin
      cnt_d = load_val & mask;
    end else if (step.up) begin
      if (cur == mask) begin
        cnt_d = '0;
        ovf   = 1'b1;
      end else begin
        cnt_d = cur + 1'b1;
      end
    end else if (step.dn) begin
      if (cur == '0) begin
        cnt_d = mask;
        unf   = 1'b1;
      end else begin
        cnt_d = cur - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cur;
endmodule

// File: rtl/quad_encoder_counter.sv
module quad_encoder_counter
  import qdec_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 10,
  parameter int FILT_DEPTH = 3,
  parameter int PRESC_W    = 8,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    enc_i,
  input  logic [NCH-1:0]    enc_q,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CTRL_W = 4 * NCH;
  localparam int FLAG_W = 2 * NCH;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] PRESC_ADDR = ADDR_W'(NCH + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // sample tick prescaler
  logic [PRESC_W-1:0] presc_q, presc_d, pcnt_q, pcnt_d;
  logic               tick;

  always_comb begin
    tick    = (pcnt_q == '0);
    pcnt_d  = tick ? presc_q : pcnt_q - 1'b1;
    presc_d = presc_q;
    if (reg_wr && reg_addr == PRESC_ADDR) presc_d = reg_wdata[PRESC_W-1:0];
  end

  // control and flags
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [FLAG_W-1:0] flags_q, flags_d, flag_set, flag_clr, flag_en;
  logic [NCH-1:0]    wide_v, up_v, dn_v, load_v, ovf_v, unf_v;
  logic [NCH-1:0][WIDE_W-1:0] load_val, cnt_v;

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr && reg_addr == CTRL_ADDR) ctrl_d = reg_wdata[CTRL_W-1:0];
    flag_clr = (reg_wr && reg_addr == STAT_ADDR) ? reg_wdata[FLAG_W-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      presc_q <= '0;
      pcnt_q  <= '0;
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      presc_q <= presc_d;
      pcnt_q  <= pcnt_d;
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
    end
  end

  // channels
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       i_f, q_f;
    qdec_step_t step;

    assign wide_v[c]      = ctrl_q[4*c];
    assign flag_en[2*c]   = ctrl_q[4*c+1];
    assign flag_en[2*c+1] = ctrl_q[4*c+2];
    assign load_v[c]      = reg_wr && (reg_addr == ADDR_W'(c));
    assign load_val[c]    = reg_wdata[WIDE_W-1:0];
    assign flag_set[2*c]   = ovf_v[c];
    assign flag_set[2*c+1] = unf_v[c];
    assign up_v[c] = step.up;
    assign dn_v[c] = step.dn;

    qdec_input_filter #(.DEPTH(FILT_DEPTH)) u_filt_i (
      .clk(clk), .rst_n(rst_n_int), .tick(tick), .raw(enc_i[c]), .filt(i_f));
    qdec_input_filter #(.DEPTH(FILT_DEPTH)) u_filt_q (
      .clk(clk), .rst_n(rst_n_int), .tick(tick), .raw(enc_q[c]), .filt(q_f));

    qdec_step_decode u_dec (
      .clk(clk), .rst_n(rst_n_int), .i_f(i_f), .q_f(q_f), .step(step));

    qdec_counter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_int), .wide(wide_v[c]), .step(step),
      .load(load_v[c]), .load_val(load_val[c]), .cnt(cnt_v[c]),
      .ovf(ovf_v[c]), .unf(unf_v[c]));
  end

  // read port
  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == ADDR_W'(c)) reg_rdata[WIDE_W-1:0] = cnt_v[c];
    end
    if (reg_addr == CTRL_ADDR)  reg_rdata[CTRL_W-1:0]  = ctrl_q;
    if (reg_addr == STAT_ADDR)  reg_rdata[FLAG_W-1:0]  = flags_q;
    if (reg_addr == PRESC_ADDR) reg_rdata[PRESC_W-1:0] = presc_q;
  end

  assign irq = |(flags_q & flag_en);
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int NCH      = 2,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             wide,
  input logic [NCH-1:0]             step_up,
  input logic [NCH-1:0]             step_dn,
  input logic [NCH-1:0]             load,
  input logic [NCH-1:0][WIDE_W-1:0] load_val,
  input logic [NCH-1:0][WIDE_W-1:0] cnt,
  input logic [2*NCH-1:0]           flags,
  input logic [2*NCH-1:0]           flag_clr,
  input logic                       irq
);
  localparam logic [WIDE_W-1:0] NMAX =
    {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [WIDE_W-1:0] top;
    assign top = wide[c] ? {WIDE_W{1'b1}} : NMAX;

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up[c] && !load[c] && cnt[c] != top) |=>
      (wide[c] != $past(wide[c])) || (cnt[c] == WIDE_W'($past(cnt[c]) + 1'b1)));

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn[c] && !load[c] && cnt[c] != '0) |=>
      (wide[c] != $past(wide[c])) || (cnt[c] == WIDE_W'($past(cnt[c]) - 1'b1)));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up[c] && !load[c] && cnt[c] == top) |=> flags[2*c]);

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load[c] |=> (wide[c] != $past(wide[c])) ||
      (cnt[c] == ($past(wide[c]) ? $past(load_val[c]) : ($past(load_val[c]) & NMAX))));
  end

  for (genvar k = 0; k < 2*NCH; k++) begin : g_flag
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !flag_clr[k]) |=> flags[k]);
  end

  p_irq_has_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
endmodule

bind quad_encoder_counter qdec_checker #(
  .NCH(NCH), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .wide(wide_v), .step_up(up_v), .step_dn(dn_v),
  .load(load_v), .load_val(load_val), .cnt(cnt_v), .flags(flags_q),
  .flag_clr(flag_clr), .irq(irq)
);

// File: tb/quad_encoder_counter_test.sv
module quad_encoder_counter_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  enc_i, enc_q;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk, n_bad;
  bit done;
  int ph[2];
  int exp0;

  quad_encoder_counter uut (
    .clk(clk), .rst_n(rst_n), .enc_i(enc_i), .enc_q(enc_q), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic check_reg(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drive(input int c);
    enc_i[c] = (ph[c] == 1 || ph[c] == 2);
    enc_q[c] = (ph[c] == 2 || ph[c] == 3);
  endtask

  task automatic step(input int c, input int dir, input int wt);
    ph[c] = (ph[c] + ((dir > 0) ? 1 : 3)) % 4;
    @(negedge clk);
    drive(c);
    repeat (wt) @(negedge clk);
  endtask

  task automatic t_reset;
    check_reg("R1 count0", 0, 0);
    check_reg("R1 count1", 1, 0);
    check_reg("R1 ctrl", 2, 0);
    check_reg("R1 flags", 3, 0);
    check_reg("R1 presc", 4, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_forward;
    for (int n = 0; n < 4; n++) step(0, 1, 10);
    check_reg("R2 four forward edges", 0, 4);
  endtask

  task automatic t_reverse;
    for (int n = 0; n < 2; n++) step(0, -1, 10);
    check_reg("R3 two reverse edges", 0, 2);
  endtask

  task automatic t_illegal;
    ph[0] = (ph[0] + 2) % 4;
    @(negedge clk);
    drive(0);
    repeat (12) @(negedge clk);
    check_reg("R4 double change ignored", 0, 2);
  endtask

  task automatic t_glitch;
    @(negedge clk);
    enc_q[0] = ~enc_q[0];
    repeat (2) @(negedge clk);
    enc_q[0] = ~enc_q[0];
    repeat (12) @(negedge clk);
    check_reg("R5 two-tick pulse ignored", 0, 2);
  endtask

  task automatic t_narrow_wrap;
    int v;
    wr(0, 254);
    step(0, 1, 10); step(0, 1, 10);
    check_reg("R6 wrap 255 to 0", 0, 0);
    check_reg("R6 overflow flag", 3, 1);
    check("R10 irq masked", int'(irq), 0);
    wr(2, 16'h0002);
    @(negedge clk);
    check("R10 irq enabled", int'(irq), 1);
    step(0, 1, 10);
    check_reg("R9 flag sticky", 3, 1);
    wr(3, 0);
    check_reg("R9 write 0 keeps flag", 3, 1);
    wr(3, 1);
    check_reg("R9 write 1 clears", 3, 0);
    check("R10 irq drops", int'(irq), 0);
    wr(0, 0);
    step(0, -1, 10);
    check_reg("R6 wrap 0 to 255", 0, 255);
    check_reg("R6 underflow flag", 3, 2);
    rd(3, v);
    check("R10 underflow not enabled", int'(irq), 0);
    wr(3, 2);
  endtask

  task automatic t_wide;
    wr(2, 16'h0001);
    wr(0, 255);
    step(0, 1, 10);
    check_reg("R7 wide passes 256", 0, 256);
    wr(0, 1023);
    step(0, 1, 10);
    check_reg("R7 wide wrap 1023 to 0", 0, 0);
    check_reg("R7 wide overflow flag", 3, 1);
    wr(3, 1);
    wr(2, 0);
  endtask

  task automatic t_priority;
    // step lands on the 6th edge after the input change; load held until it
    ph[0] = (ph[0] + 1) % 4;
    @(negedge clk);
    drive(0);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'd100;
    repeat (6) @(negedge clk);
    reg_wr = 1'b0;
    repeat (8) @(negedge clk);
    check_reg("R8 load wins over step", 0, 100);
    step(0, 1, 10);
    check_reg("R8 next step counts", 0, 101);
  endtask

  task automatic t_channels;
    wr(2, 16'h0040);
    step(1, -1, 10);
    check_reg("R11 ch1 wraps down", 1, 255);
    check_reg("R11 ch0 untouched", 0, 101);
    check_reg("R6 ch1 underflow flag bit 3", 3, 8);
    check("R10 ch1 underflow irq", int'(irq), 1);
    wr(3, 8);
    wr(2, 0);
  endtask

  task automatic t_prescaler;
    wr(4, 3);
    check_reg("R12 prescaler readback", 4, 3);
    @(negedge clk);
    enc_i[1] = ~enc_i[1];
    repeat (7) @(negedge clk);
    enc_i[1] = ~enc_i[1];
    repeat (30) @(negedge clk);
    check_reg("R12 7-clock pulse rejected", 1, 255);
    step(1, 1, 40);
    check_reg("R12 slow edge counted", 1, 0);
    wr(4, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0; ph[0] = 0; ph[1] = 0;
    rst_n = 1'b0; enc_i = '0; enc_q = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_illegal();
    t_glitch();
    t_narrow_wrap();
    t_wide();
    t_priority();
    t_channels();
    t_prescaler();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule